// File: doc/BRIEF.md
# HDLC Receive Deframer

The deframer accepts a serial HDLC bit stream, one bit per cycle in which `bit_en` is high. It hunts for the 01111110 flag and treats the stretch between two flags as a frame. Inside a frame it removes each zero that was stuffed after five ones and packs the remaining bits into octets, first-received bit in bit 0. It runs a CRC-16-CCITT over every data bit. Each completed octet, the two FCS octets included, is placed on an 8-bit bus together with a one-cycle data strobe. A downstream register can capture the bus on the falling edge that follows the strobe's rising edge.

Frame outcome is not given as separate good, bad and abort flags. Two status outputs, `rx_idle` and `rx_fcs_ok`, together carry a code. A third strobe, `rx_end`, marks the cycles in which that code describes the end of a frame and not an ordinary flag. The flag-only code (`rx_idle` high, `rx_fcs_ok` low) is exactly what a bad frame end shows, so `rx_end` is what tells the two apart. Every status output is a one-cycle pulse issued one clock after the input bit that caused it. A run of seven ones inside a frame aborts it. The deframer then discards the frame and waits for the next flag.

Top module: `hdlc_rx_deframer`

## Requirements
- R1: While reset is asserted and in the cycle after it is released, `rx_data_en`, `rx_idle`, `rx_fcs_ok` and `rx_end` are all low.
- R2: Every flag detected raises `rx_idle` for one cycle, one clock after the `bit_en` cycle that completed it. A flag that follows another flag with no data bits between them gives the code idle=1, fcs_ok=0, end=0.
- R3: Inside a frame, a zero that follows five consecutive data ones is dropped. Octets are assembled with the first-received bit in bit 0. Each octet, FCS octets included, appears on `rx_data` with a one-cycle `rx_data_en` pulse.
- R4: A closing flag ends a frame as good when three conditions hold: the frame has at least two octets, it ends on an octet boundary, and its CRC residue is 0xF0B8. The CRC is preset to 0xFFFF and uses the reflected polynomial 0x8408, fed least significant bit first. A good end gives idle=1, fcs_ok=1, end=1 for one cycle.
- R5: A frame that ends with a wrong CRC residue gives idle=1, fcs_ok=0, end=1.
- R6: A frame with fewer than two octets is reported as bad (idle=1, fcs_ok=0, end=1). A frame of exactly two octets holding the FCS of an empty payload is reported as good.
- R7: A frame whose bit count after destuffing is not a multiple of eight is reported as bad.
- R8: Seven consecutive ones while a frame is open give idle=0, fcs_ok=1, end=1. The frame is discarded, no octet in progress is emitted, and the deframer waits for a flag. That next flag reports the flag-only code.
- R9: A single flag both closes one frame and opens the next, so back-to-back frames are each reported.
- R10: `rx_data_en` rises only in the cycle after a `bit_en` cycle, and `rx_end` never stays high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | Qualifies `bit_in` for this cycle |
| bit_in | input | 1 | Serial received bit |
| rx_data | output | 8 | Received octet |
| rx_data_en | output | 1 | One-cycle strobe, `rx_data` holds a new octet |
| rx_idle | output | 1 | Status code bit, pulses on every flag |
| rx_fcs_ok | output | 1 | Status code bit, qualifies frame outcome |
| rx_end | output | 1 | Marks a status code that ends a frame (good, bad or abort) |

## Verification
The bench builds the deframer with its default parameters: an 8-bit flag window, a five-one stuffing run, a seven-one abort run, a two-octet minimum and the CCITT residue. With these values a frame of only two FCS octets becomes the exact boundary between a short frame and a good one. Payload octets 0xFF, 0x7E, 0x3F and 0xF8 force stuffed zeros to cross octet boundaries. An abort placed seven bits after an octet starts lands while that octet is only partly assembled. Bits are offered every other cycle, so the one-cycle delay from a `bit_en` cycle to its outputs is visible apart from the clock.

// File: rtl/hdlc_rx_pkg.sv
package hdlc_rx_pkg;
  localparam int OCTET_W = 8;
  localparam int CRC_W   = 16;

  // One bit of a reflected CRC, fed least significant bit first.
  function automatic logic [CRC_W-1:0] crc_lsb_step(
    input logic [CRC_W-1:0] cur,
    input logic             din,
    input logic [CRC_W-1:0] poly_rev
  );
    logic [CRC_W-1:0] shifted;
    shifted = cur >> 1;
    return (cur[0] ^ din) ? (shifted ^ poly_rev) : shifted;
  endfunction

  // Status code bits as seen on {rx_idle, rx_fcs_ok, rx_end}.
  typedef enum logic [2:0] {
    ST_NONE  = 3'b000,
    ST_FLAG  = 3'b100,
    ST_GOOD  = 3'b111,
    ST_BAD   = 3'b101,
    ST_ABORT = 3'b011
  } rx_status_e;
endpackage

// File: rtl/hdlc_flag_scan.sv
module hdlc_flag_scan #(
  parameter int          WIN_W     = 8,
  parameter logic [7:0]  FLAG_PAT  = 8'h7E,
  parameter int          ABORT_RUN = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_en,
  input  logic bit_in,
  output logic flag_hit,
  output logic abort_hit,
  output logic drop_vld,
  output logic drop_bit
);
  localparam int CNT_W = $clog2(WIN_W + 1);
  localparam int RUN_W = $clog2(ABORT_RUN + 1);

  logic [WIN_W-1:0] win_q, win_n;
  logic [CNT_W-1:0] fill_q;
  logic [RUN_W-1:0] run_q;

  // Newest bit enters at the top, oldest leaves from bit 0.
  assign win_n     = {bit_in, win_q[WIN_W-1:1]};
  assign flag_hit  = bit_en && (win_n == FLAG_PAT);
  assign abort_hit = bit_en && bit_in && (run_q == RUN_W'(ABORT_RUN - 1));
  // A bit leaving the window is data only once a whole window has
  // passed since the last flag, so flag bits never reach the payload.
  assign drop_vld  = bit_en && (fill_q == CNT_W'(WIN_W));
  assign drop_bit  = win_q[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      win_q  <= '0;
      fill_q <= '0;
      run_q  <= '0;
    end else if (bit_en) begin
      win_q <= win_n;
      if (!bit_in)                            run_q <= '0;
      else if (run_q != RUN_W'(ABORT_RUN))    run_q <= run_q + 1'b1;
      if (flag_hit)                           fill_q <= '0;
      else if (fill_q != CNT_W'(WIN_W))       fill_q <= fill_q + 1'b1;
    end
  end
endmodule

// File: rtl/hdlc_octet_collect.sv
module hdlc_octet_collect
  import hdlc_rx_pkg::*;
#(
  parameter int                STUFF_RUN    = 5,
  parameter int                MIN_OCTETS   = 2,
  parameter logic [CRC_W-1:0]  CRC_INIT     = 16'hFFFF,
  parameter logic [CRC_W-1:0]  CRC_POLY_REV = 16'h8408,
  parameter logic [CRC_W-1:0]  CRC_GOOD     = 16'hF0B8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bit_vld,
  input  logic               bit_d,
  input  logic               clear,
  output logic               byte_done,
  output logic [OCTET_W-1:0] byte_val,
  output logic               any_n,
  output logic               aligned_n,
  output logic               long_n,
  output logic               crc_ok_n
);
  localparam int ONES_W = $clog2(STUFF_RUN + 2);
  localparam int BIT_W  = $clog2(OCTET_W);
  localparam int NB_W   = $clog2(MIN_OCTETS + 1);

  logic [ONES_W-1:0]  ones_q, ones_n;
  logic [CRC_W-1:0]   crc_q, crc_n;
  logic [OCTET_W-1:0] sh_q, sh_n;
  logic [BIT_W-1:0]   bcnt_q, bcnt_n;
  logic [NB_W-1:0]    nb_q, nb_n;
  logic               got_q;
  logic               stuffed, take;

  assign stuffed = bit_vld && !bit_d && (ones_q == ONES_W'(STUFF_RUN));
  assign take    = bit_vld && !stuffed;

  always_comb begin
    ones_n = ones_q;
    if (bit_vld) begin
      if (!bit_d)                                 ones_n = '0;
      else if (ones_q != ONES_W'(STUFF_RUN + 1))  ones_n = ones_q + 1'b1;
    end
    sh_n   = take ? {bit_d, sh_q[OCTET_W-1:1]} : sh_q;
    bcnt_n = take ? bcnt_q + 1'b1 : bcnt_q;
    crc_n  = take ? crc_lsb_step(crc_q, bit_d, CRC_POLY_REV) : crc_q;
  end

  assign byte_done = take && (bcnt_q == BIT_W'(OCTET_W - 1));
  assign byte_val  = sh_n;
  assign nb_n      = (byte_done && nb_q != NB_W'(MIN_OCTETS)) ? nb_q + 1'b1 : nb_q;
  assign any_n     = got_q || take;
  assign aligned_n = (bcnt_n == '0);
  assign long_n    = (nb_n == NB_W'(MIN_OCTETS));
  assign crc_ok_n  = (crc_n == CRC_GOOD);

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      ones_q <= '0;
      crc_q  <= CRC_INIT;
      sh_q   <= '0;
      bcnt_q <= '0;
      nb_q   <= '0;
      got_q  <= 1'b0;
    end else begin
      ones_q <= ones_n;
      crc_q  <= crc_n;
      sh_q   <= sh_n;
      bcnt_q <= bcnt_n;
      nb_q   <= nb_n;
      got_q  <= any_n;
    end
  end
endmodule

// File: rtl/hdlc_rx_deframer.sv
module hdlc_rx_deframer
  import hdlc_rx_pkg::*;
#(
  parameter int          WIN_W      = 8,
  parameter logic [7:0]  FLAG_PAT   = 8'h7E,
  parameter int          ABORT_RUN  = 7,
  parameter int          STUFF_RUN  = 5,
  parameter int          MIN_OCTETS = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bit_en,
  input  logic               bit_in,
  output logic [OCTET_W-1:0] rx_data,
  output logic               rx_data_en,
  output logic               rx_idle,
  output logic               rx_fcs_ok,
  output logic               rx_end
);
  logic               flag_hit, abort_hit, drop_vld, drop_bit;
  logic               byte_done, any_n, aligned_n, long_n, crc_ok_n;
  logic [OCTET_W-1:0] byte_val;
  logic               in_frame;
  logic               feed, frame_end, frame_abort, frame_good, clear;

  hdlc_flag_scan #(
    .WIN_W(WIN_W), .FLAG_PAT(FLAG_PAT), .ABORT_RUN(ABORT_RUN)
  ) u_scan (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .bit_in(bit_in),
    .flag_hit(flag_hit), .abort_hit(abort_hit),
    .drop_vld(drop_vld), .drop_bit(drop_bit)
  );

  assign feed        = drop_vld && in_frame;
  assign frame_end   = flag_hit && in_frame && any_n;
  assign frame_abort = abort_hit && in_frame;
  assign frame_good  = aligned_n && long_n && crc_ok_n;
  assign clear       = flag_hit || frame_abort;

  hdlc_octet_collect #(
    .STUFF_RUN(STUFF_RUN), .MIN_OCTETS(MIN_OCTETS)
  ) u_collect (
    .clk(clk), .rst_n(rst_n), .bit_vld(feed), .bit_d(drop_bit),
    .clear(clear), .byte_done(byte_done), .byte_val(byte_val),
    .any_n(any_n), .aligned_n(aligned_n), .long_n(long_n),
    .crc_ok_n(crc_ok_n)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_frame   <= 1'b0;
      rx_data    <= '0;
      rx_data_en <= 1'b0;
      rx_idle    <= 1'b0;
      rx_fcs_ok  <= 1'b0;
      rx_end     <= 1'b0;
    end else begin
      rx_data_en <= byte_done && !frame_abort;
      if (byte_done) rx_data <= byte_val;
      rx_idle    <= flag_hit;
      rx_fcs_ok  <= (frame_end && frame_good) || frame_abort;
      rx_end     <= frame_end || frame_abort;
      if (flag_hit)         in_frame <= 1'b1;
      else if (frame_abort) in_frame <= 1'b0;
    end
  end
endmodule

// File: rtl/hdlc_rx_chk.sv
module hdlc_rx_chk (
  input logic clk,
  input logic rst_n,
  input logic bit_en,
  input logic flag_hit,
  input logic abort_hit,
  input logic rx_data_en,
  input logic rx_idle,
  input logic rx_fcs_ok,
  input logic rx_end
);
  // R2
  flag_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag_hit |=> rx_idle);
  // R2
  idle_has_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_idle |-> $past(flag_hit));
  // R8
  abort_code_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_end && !rx_idle) |-> $past(abort_hit));
  // R4
  fcs_ok_needs_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_fcs_ok |-> rx_end);
  // R5
  end_code_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_end |-> (rx_idle || rx_fcs_ok));
  // R10
  data_after_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_data_en |-> $past(bit_en));
  // R10
  end_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_end |=> !rx_end);
endmodule

bind hdlc_rx_deframer hdlc_rx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .flag_hit(flag_hit),
  .abort_hit(abort_hit), .rx_data_en(rx_data_en), .rx_idle(rx_idle),
  .rx_fcs_ok(rx_fcs_ok), .rx_end(rx_end)
);

// File: tb/tb_hdlc_rx_deframer.sv
module tb_hdlc_rx_deframer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bit_en = 1'b0;
  logic       bit_in = 1'b0;
  logic [7:0] rx_data;
  logic       rx_data_en, rx_idle, rx_fcs_ok, rx_end;

  int n_checks = 0;
  int n_fails  = 0;
  int tx_ones  = 0;

  logic [7:0] pay_q[$];
  logic [7:0] exp_b[$];
  logic [7:0] got_b[$];
  logic [2:0] exp_e[$];
  logic [2:0] got_e[$];

  localparam logic [2:0] C_FLAG  = 3'b100;
  localparam logic [2:0] C_GOOD  = 3'b111;
  localparam logic [2:0] C_BAD   = 3'b101;
  localparam logic [2:0] C_ABORT = 3'b011;

  always #10 clk = ~clk;

  hdlc_rx_deframer dut (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .bit_in(bit_in),
    .rx_data(rx_data), .rx_data_en(rx_data_en), .rx_idle(rx_idle),
    .rx_fcs_ok(rx_fcs_ok), .rx_end(rx_end)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (rx_data_en) got_b.push_back(rx_data);
      if (rx_idle || rx_fcs_ok || rx_end) got_e.push_back({rx_idle, rx_fcs_ok, rx_end});
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic put_bit(input logic b);
    @(negedge clk);
    bit_en = 1'b1;
    bit_in = b;
    @(negedge clk);
    bit_en = 1'b0;
  endtask

  task automatic send_flag();
    for (int i = 0; i < 8; i++) put_bit((i == 0 || i == 7) ? 1'b0 : 1'b1);
    tx_ones = 0;
  endtask

  task automatic send_octet(input logic [7:0] v);
    for (int i = 0; i < 8; i++) begin
      put_bit(v[i]);
      if (v[i]) tx_ones++; else tx_ones = 0;
      if (tx_ones == 5) begin
        put_bit(1'b0);
        tx_ones = 0;
      end
    end
  endtask

  // FCS computed with the non-reflected polynomial on a mirrored register.
  function automatic logic [15:0] bench_fcs();
    logic [15:0] r, m;
    logic fb;
    r = 16'hFFFF;
    foreach (pay_q[k]) begin
      for (int i = 0; i < 8; i++) begin
        fb = r[15] ^ pay_q[k][i];
        r  = {r[14:0], 1'b0};
        if (fb) r = r ^ 16'h1021;
      end
    end
    for (int i = 0; i < 16; i++) m[i] = r[15-i];
    return ~m;
  endfunction

  // Sends pay_q followed by its FCS; corrupt flips one payload bit after FCS.
  task automatic send_body(input bit corrupt);
    logic [15:0] f;
    f = bench_fcs();
    if (corrupt) pay_q[0] = pay_q[0] ^ 8'h04;
    foreach (pay_q[k]) begin
      send_octet(pay_q[k]);
      exp_b.push_back(pay_q[k]);
    end
    send_octet(f[7:0]);
    send_octet(f[15:8]);
    exp_b.push_back(f[7:0]);
    exp_b.push_back(f[15:8]);
  endtask

  task automatic begin_case();
    got_b.delete(); got_e.delete(); exp_b.delete(); exp_e.delete(); pay_q.delete();
  endtask

  task automatic finish_case(input string req);
    repeat (4) @(negedge clk);
    check({req, " event count"}, got_e.size(), exp_e.size());
    foreach (exp_e[k]) if (k < got_e.size()) check({req, " status code"}, got_e[k], exp_e[k]);
    check({req, " octet count"}, got_b.size(), exp_b.size());
    foreach (exp_b[k]) if (k < got_b.size()) check({req, " octet value"}, got_b[k], exp_b[k]);
  endtask

  task automatic t_reset();
    // R1
    check("R1 data_en", rx_data_en, 0);
    check("R1 idle", rx_idle, 0);
    check("R1 fcs_ok", rx_fcs_ok, 0);
    check("R1 end", rx_end, 0);
  endtask

  task automatic t_idle_flags();
    // R2
    begin_case();
    repeat (3) begin send_flag(); exp_e.push_back(C_FLAG); end
    finish_case("R2");
  endtask

  task automatic t_good_stuffed();
    // R3 R4
    begin_case();
    pay_q = '{8'hFF, 8'h7E, 8'h3F, 8'hF8, 8'h12};
    send_flag(); exp_e.push_back(C_FLAG);
    send_body(1'b0);
    send_flag(); exp_e.push_back(C_GOOD);
    finish_case("R3 R4");
  endtask

  task automatic t_bad_fcs();
    // R5
    begin_case();
    pay_q = '{8'hA1, 8'h5C, 8'h00};
    send_flag(); exp_e.push_back(C_FLAG);
    send_body(1'b1);
    send_flag(); exp_e.push_back(C_BAD);
    finish_case("R5");
  endtask

  task automatic t_short();
    // R6
    begin_case();
    send_flag(); exp_e.push_back(C_FLAG);
    send_octet(8'hA5); exp_b.push_back(8'hA5);
    send_flag(); exp_e.push_back(C_BAD);
    finish_case("R6 short");
  endtask

  task automatic t_min_good();
    // R6
    begin_case();
    send_flag(); exp_e.push_back(C_FLAG);
    send_body(1'b0);
    send_flag(); exp_e.push_back(C_GOOD);
    finish_case("R6 minimum");
  endtask

  task automatic t_unaligned();
    // R7
    begin_case();
    pay_q = '{8'h33, 8'hC4};
    send_flag(); exp_e.push_back(C_FLAG);
    send_body(1'b0);
    repeat (3) put_bit(1'b0);
    send_flag(); exp_e.push_back(C_BAD);
    finish_case("R7");
  endtask

  task automatic t_abort();
    // R8
    begin_case();
    send_flag(); exp_e.push_back(C_FLAG);
    send_octet(8'h12); exp_b.push_back(8'h12);
    send_octet(8'h34);
    repeat (8) put_bit(1'b1);
    exp_e.push_back(C_ABORT);
    send_flag(); exp_e.push_back(C_FLAG);
    finish_case("R8");
  endtask

  task automatic t_shared_flag();
    // R9
    begin_case();
    send_flag(); exp_e.push_back(C_FLAG);
    pay_q = '{8'h01, 8'h02};
    send_body(1'b0);
    send_flag(); exp_e.push_back(C_GOOD);
    pay_q.delete();
    pay_q = '{8'hEE};
    send_body(1'b0);
    send_flag(); exp_e.push_back(C_GOOD);
    finish_case("R9");
  endtask

  task automatic t_timing();
    // R10: a status pulse follows the enabled bit by one clock and lasts one cycle
    begin_case();
    send_flag();
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      bit_en = 1'b1;
      bit_in = (i == 0 || i == 7) ? 1'b0 : 1'b1;
      @(negedge clk);
      bit_en = 1'b0;
      if (i == 7) check("R10 idle one clock after bit", rx_idle, 1);
      else        check("R10 no early idle", rx_idle, 0);
    end
    @(negedge clk);
    check("R10 idle lasts one cycle", rx_idle, 0);
    tx_ones = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_idle_flags();
    t_good_stuffed();
    t_bad_fcs();
    t_short();
    t_min_good();
    t_unaligned();
    t_abort();
    t_shared_flag();
    t_timing();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule